// File: doc/BRIEF.md
# Odd-Even Merge Sorting Network

This block puts N unsigned keys into ascending order in one pass through a fixed network of compare-exchange cells. Every cell looks at two keys and places the smaller on its lower-indexed line and the larger on its higher-indexed line. A pair of equal keys passes through unswapped. The network has no feedback and no control program. The same wiring therefore sorts every input vector in the same time.

The network is built recursively. A sorter of N keys is two sorters of N/2 keys followed by a merger of N inputs. A merger of two sorted halves works in two steps. First it merges the even-position elements of both halves and, separately, the odd-position elements of both halves, using two half-size mergers. Then one column of cross comparators joins the two results. In total, sorted pairs grow into sorted runs of four, then eight, and so on, until one final merger combines the two halves. The result can be registered once at the output, which is the default, or passed straight through.

Keys are packed into one flat vector. Key j occupies bits [j*W +: W], and index 0 receives the smallest result. A valid strobe travels with the data.

Top module: `oems_sorter`

## Requirements
- R1: Whenever out_valid is high, out_keys holds keys in non-decreasing order from index 0 (lowest bits) to index N-1.
- R2: The output keys are a permutation of the input keys that were presented with in_valid. No key is lost, duplicated or altered.
- R3: With the output register enabled (OUT_REG=1), the sorted result and out_valid appear one clock after in_valid was high. out_valid is low on the clock after in_valid was low.
- R4: While rst_n is low, out_valid is low. This holds asynchronously, without waiting for a clock edge. out_valid stays low after release until a key vector is accepted.
- R5: While in_valid is low, out_keys keep their previous value, whatever in_keys carries.
- R6: Equal keys are never swapped, so a vector of identical keys comes out unchanged.
- R7: N is a parameter. Any power of two of at least 2 gives a correct sorter, and any other value stops elaboration with an error.
- R8: A merger of 2m inputs contains 1 + m*log2(m) comparators and has depth 1 + log2(m). For N=8 the merger has 9 comparators and depth 3, and the whole sorter has 19 comparators. The package functions yield these counts at compile time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input vector is valid and is loaded |
| in_keys | input | N*W | Unsorted keys; key j at bits [j*W +: W] |
| out_valid | output | 1 | Sorted vector is valid |
| out_keys | output | N*W | Keys in ascending order, smallest at index 0 |

## Verification
All 256 vectors of zeros and ones for N=8 are applied. A miswired cross column or a wrong odd/even split shows up there as a single out-of-place one. Equal and duplicated keys, including all-equal vectors, are applied. These catch a comparator that loses or duplicates a key when it tests with the wrong relation. Keys at 0x0000 and 0xFFFF catch a comparison done as signed or truncated. Random 16-bit vectors are compared with a reference sort. A second instance with N=4 exercises the recursion at another size. Idle cycles and a reset during activity check that stale data holds and that out_valid drops without waiting for a clock.

// File: rtl/oems_pkg.sv
`timescale 1ns/1ps
package oems_pkg;

  // True when v is a power of two of at least 2.
  function automatic bit is_pow2(input int v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

  // Comparators in a merger with n inputs in total.
  function automatic int merge_cmp(input int n);
    if (n <= 2) return 1;
    return 2 * merge_cmp(n / 2) + n / 2 - 1;
  endfunction

  // Stages in a merger with n inputs in total.
  function automatic int merge_depth(input int n);
    if (n <= 2) return 1;
    return merge_depth(n / 2) + 1;
  endfunction

  // Comparators in a full sorter of n keys.
  function automatic int sort_cmp(input int n);
    if (n <= 2) return 1;
    return 2 * sort_cmp(n / 2) + merge_cmp(n);
  endfunction

  // Stages in a full sorter of n keys.
  function automatic int sort_depth(input int n);
    if (n <= 2) return 1;
    return sort_depth(n / 2) + merge_depth(n);
  endfunction

endpackage

// File: rtl/oems_cmpx.sv
`timescale 1ns/1ps
// One compare-exchange cell: smaller key to lo_o, larger to hi_o.
module oems_cmpx #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic swap;

  // Strict compare: equal keys stay in place.
  assign swap = (a_i > b_i);
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/oems_merge.sv
`timescale 1ns/1ps
// Merges two sorted halves of L keys (L a power of two).
// keys_i[0 .. L/2-1] and keys_i[L/2 .. L-1] must each be ascending.
module oems_merge #(
  parameter int W = 16,
  parameter int L = 8
) (
  input  logic [L*W-1:0] keys_i,
  output logic [L*W-1:0] keys_o
);
  generate
    if (L == 2) begin : g_leaf
      oems_cmpx #(.W(W)) u_cx (
        .a_i (keys_i[0 +: W]),
        .b_i (keys_i[W +: W]),
        .lo_o(keys_o[0 +: W]),
        .hi_o(keys_o[W +: W])
      );
    end else begin : g_rec
      localparam int H = L / 2;
      localparam int Q = L / 4;
      logic [H*W-1:0] ev_in, od_in, ev_m, od_m;

      // Split each half into its even- and odd-position subsequences.
      for (genvar k = 0; k < Q; k++) begin : g_split
        assign ev_in[k*W +: W]     = keys_i[(2*k)*W +: W];
        assign ev_in[(Q+k)*W +: W] = keys_i[(H+2*k)*W +: W];
        assign od_in[k*W +: W]     = keys_i[(2*k+1)*W +: W];
        assign od_in[(Q+k)*W +: W] = keys_i[(H+2*k+1)*W +: W];
      end

      oems_merge #(.W(W), .L(H)) u_ev (.keys_i(ev_in), .keys_o(ev_m));
      oems_merge #(.W(W), .L(H)) u_od (.keys_i(od_in), .keys_o(od_m));

      // The ends need no comparator.
      assign keys_o[0 +: W]         = ev_m[0 +: W];
      assign keys_o[(L-1)*W +: W]   = od_m[(H-1)*W +: W];

      // Final cross column of H-1 comparators.
      for (genvar i = 1; i < H; i++) begin : g_cross
        oems_cmpx #(.W(W)) u_cx (
          .a_i (ev_m[i*W +: W]),
          .b_i (od_m[(i-1)*W +: W]),
          .lo_o(keys_o[(2*i-1)*W +: W]),
          .hi_o(keys_o[(2*i)*W +: W])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/oems_sort.sv
`timescale 1ns/1ps
// Full combinational sorter of L keys: two half sorters, then one merger.
module oems_sort #(
  parameter int W = 16,
  parameter int L = 8
) (
  input  logic [L*W-1:0] keys_i,
  output logic [L*W-1:0] keys_o
);
  generate
    if (L == 2) begin : g_leaf
      oems_cmpx #(.W(W)) u_cx (
        .a_i (keys_i[0 +: W]),
        .b_i (keys_i[W +: W]),
        .lo_o(keys_o[0 +: W]),
        .hi_o(keys_o[W +: W])
      );
    end else begin : g_rec
      localparam int H = L / 2;
      logic [L*W-1:0] halves;

      oems_sort #(.W(W), .L(H)) u_lo (
        .keys_i(keys_i[0 +: H*W]),
        .keys_o(halves[0 +: H*W])
      );
      oems_sort #(.W(W), .L(H)) u_hi (
        .keys_i(keys_i[H*W +: H*W]),
        .keys_o(halves[H*W +: H*W])
      );
      oems_merge #(.W(W), .L(L)) u_mrg (
        .keys_i(halves),
        .keys_o(keys_o)
      );
    end
  endgenerate
endmodule

// File: rtl/oems_sorter.sv
`timescale 1ns/1ps
// Top: sorting network with optional output register.
module oems_sorter #(
  parameter int N       = 8,
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_keys,
  output logic           out_valid,
  output logic [N*W-1:0] out_keys
);
  localparam int NUM_CMP = oems_pkg::sort_cmp(N);
  localparam int DEPTH   = oems_pkg::sort_depth(N);

  logic [N*W-1:0] net_keys;

  generate
    if (!oems_pkg::is_pow2(N) || NUM_CMP < 1 || DEPTH < 1) begin : g_bad_n
      $error("oems_sorter: N must be a power of two of at least 2");
    end
  endgenerate

  oems_sort #(.W(W), .L(N)) u_net (
    .keys_i(in_keys),
    .keys_o(net_keys)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic           valid_d, valid_q;
      logic [N*W-1:0] keys_d, keys_q;
      logic           keys_en;

      // Next-state logic.
      always_comb begin
        valid_d = in_valid;
        keys_en = in_valid;
        keys_d  = net_keys;
      end

      // Control register with async reset.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
      end

      // Data register, enable only, no reset.
      always_ff @(posedge clk) begin
        if (keys_en) keys_q <= keys_d;
      end

      assign out_valid = valid_q;
      assign out_keys  = keys_q;
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_keys  = net_keys;
    end
  endgenerate
endmodule

// File: rtl/oems_sorter_chk.sv
`timescale 1ns/1ps
module oems_sorter_chk #(
  parameter int N       = 8,
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N*W-1:0] in_keys,
  input logic           out_valid,
  input logic [N*W-1:0] out_keys
);
  localparam int SW = W + $clog2(N) + 1;

  function automatic bit ascending(input logic [N*W-1:0] v);
    for (int j = 1; j < N; j++)
      if (v[j*W +: W] < v[(j-1)*W +: W]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [SW-1:0] keysum(input logic [N*W-1:0] v);
    logic [SW-1:0] s;
    s = '0;
    for (int j = 0; j < N; j++) s = s + SW'(v[j*W +: W]);
    return s;
  endfunction

  // R4: out_valid low while reset is applied.
  always @(negedge clk) begin
    if (!rst_n) a_r4_reset_low: assert (!out_valid);
  end

  generate
    if (OUT_REG) begin : g_reg_chk
      a_r1_sorted: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ascending(out_keys));
      a_r2_keys_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> keysum(out_keys) == $past(keysum(in_keys)));
      a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r3_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_keys));
    end else begin : g_comb_chk
      always @(negedge clk) begin
        if (rst_n && out_valid) begin
          a_r1_sorted_comb: assert (ascending(out_keys));
          a_r2_keys_kept_comb: assert (keysum(out_keys) == keysum(in_keys));
        end
      end
    end
  endgenerate
endmodule

bind oems_sorter oems_sorter_chk #(.N(N), .W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_keys  (in_keys),
  .out_valid(out_valid),
  .out_keys (out_keys)
);

// File: tb/oems_sorter_test.sv
`timescale 1ns/1ps
module oems_sorter_test;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int NV = 6;
  localparam int N4 = 4;
  localparam int W4 = 8;

  // Stimulus and expected results; key j at bits [j*W +: W].
  localparam logic [N*W-1:0] TV_IN [NV] = '{
    {16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7},
    {16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0},
    {8{16'h5A5A}},
    {16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF},
    {16'd1, 16'd2, 16'd3, 16'd1, 16'd2, 16'd3, 16'd1, 16'd3},
    {16'hABCD, 16'h0000, 16'h8000, 16'h1234, 16'hFFFE, 16'h0001, 16'h7FFF, 16'h8000}
  };
  localparam logic [N*W-1:0] TV_OUT [NV] = '{
    {16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0},
    {16'd7, 16'd6, 16'd5, 16'd4, 16'd3, 16'd2, 16'd1, 16'd0},
    {8{16'h5A5A}},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {16'd3, 16'd3, 16'd3, 16'd2, 16'd2, 16'd1, 16'd1, 16'd1},
    {16'hFFFE, 16'hABCD, 16'h8000, 16'h8000, 16'h7FFF, 16'h1234, 16'h0001, 16'h0000}
  };
  localparam string TV_REQ [NV] = '{"R1", "R2", "R6", "R1", "R2", "R1"};

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [N*W-1:0] in_keys;
  logic           out_valid;
  logic [N*W-1:0] out_keys;

  logic             in4_valid;
  logic [N4*W4-1:0] in4_keys;
  logic             out4_valid;
  logic [N4*W4-1:0] out4_keys;

  int checks = 0;
  int fails  = 0;

  oems_sorter #(.N(N), .W(W), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_keys(in_keys),
    .out_valid(out_valid), .out_keys(out_keys)
  );

  oems_sorter #(.N(N4), .W(W4), .OUT_REG(1'b1)) uut4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in4_valid), .in_keys(in4_keys),
    .out_valid(out4_valid), .out_keys(out4_keys)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk_vec(input string req, input logic [N*W-1:0] act,
                         input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference ascending sort, independent of the network.
  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int j = 0; j < N; j++) a[j] = v[j*W +: W];
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0; j--)
        if (a[j] < a[j-1]) begin
          t = a[j]; a[j] = a[j-1]; a[j-1] = t;
        end
    for (int j = 0; j < N; j++) r[j*W +: W] = a[j];
    return r;
  endfunction

  // Drive one vector, then sample one clock later, away from the edge.
  task automatic apply(input logic [N*W-1:0] keys, output logic [N*W-1:0] got,
                       output logic got_v);
    @(negedge clk);
    in_valid = 1'b1;
    in_keys  = keys;
    @(negedge clk);
    got   = out_keys;
    got_v = out_valid;
  endtask

  initial begin
    logic [N*W-1:0] got, last, v;
    logic           gv;
    rst_n = 1'b0; in_valid = 1'b0; in_keys = '0;
    in4_valid = 1'b0; in4_keys = '0;

    // R4: reset state.
    repeat (3) @(negedge clk);
    chk_bit("R4", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R4", out_valid, 1'b0);

    // R8: compile-time comparator counts and depth.
    chk_int("R8", oems_pkg::merge_cmp(8), 9);
    chk_int("R8", oems_pkg::merge_depth(8), 3);
    chk_int("R8", oems_pkg::sort_cmp(8), 19);
    chk_int("R8", oems_pkg::merge_cmp(16), 1 + 8 * 3);

    // Table of directed vectors (R1, R2, R6, R3).
    for (int i = 0; i < NV; i++) begin
      apply(TV_IN[i], got, gv);
      chk_vec(TV_REQ[i], got, TV_OUT[i]);
      chk_bit("R3", gv, 1'b1);
    end
    last = TV_OUT[NV-1];

    // R5: idle input with garbage keys leaves the output alone.
    @(negedge clk);
    in_valid = 1'b0;
    in_keys  = {8{16'h1357}};
    @(negedge clk);
    chk_vec("R5", out_keys, last);
    chk_bit("R3", out_valid, 1'b0);
    in_keys  = {8{16'hEEEE}};
    @(negedge clk);
    chk_vec("R5", out_keys, last);

    // R1: every 0/1 pattern for N=8.
    for (int p = 0; p < (1 << N); p++) begin
      logic [N*W-1:0] exp;
      int ones;
      ones = $countones(p[N-1:0]);
      for (int j = 0; j < N; j++) begin
        v[j*W +: W]   = W'(p[j]);
        exp[j*W +: W] = (j >= N - ones) ? W'(1) : W'(0);
      end
      apply(v, got, gv);
      chk_vec("R1", got, exp);
    end

    // R2: random wide keys against the reference sort.
    for (int n = 0; n < 200; n++) begin
      for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
      if (n % 4 == 0) v[3*W +: W] = v[5*W +: W];
      apply(v, got, gv);
      chk_vec("R2", got, ref_sort(v));
    end

    // R7: a second size, N=4.
    @(negedge clk);
    in_valid  = 1'b0;
    in4_valid = 1'b1;
    in4_keys  = {8'd2, 8'd7, 8'd2, 8'd9};
    @(negedge clk);
    checks++;
    if (out4_keys !== {8'd9, 8'd7, 8'd2, 8'd2}) begin
      fails++;
      $display("FAIL R7: got %h expected %h", out4_keys, {8'd9, 8'd7, 8'd2, 8'd2});
    end
    in4_keys = {8'h00, 8'hFF, 8'h80, 8'h7F};
    @(negedge clk);
    checks++;
    if (out4_keys !== {8'hFF, 8'h80, 8'h7F, 8'h00}) begin
      fails++;
      $display("FAIL R7: got %h expected %h", out4_keys, {8'hFF, 8'h80, 8'h7F, 8'h00});
    end
    in4_valid = 1'b0;

    // R4: reset while busy drops out_valid without a clock edge.
    in_valid = 1'b1;
    in_keys  = TV_IN[0];
    @(negedge clk);
    chk_bit("R3", out_valid, 1'b1);
    #1 rst_n = 1'b0;
    #0.5;
    chk_bit("R4", out_valid, 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit("R4", out_valid, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule